// File: doc/BRIEF.md
# ADC Conversion and Serial Transfer Sequencer

This block sits on the host side of a 12-bit successive-approximation converter that has a synchronous serial port. It keeps the converter sampling back to back. It raises a convert-start strobe, then runs a 16-bit framed transfer at once. The transfer overlaps the conversion now in progress. It shifts a control word out and, in the same frame, shifts in the result of the previous conversion. The sequencer then waits until the converter's busy flag drops, lets a minimum settling gap elapse, and starts again.

A static mode input selects software-triggered operation. In that mode the strobe stays low, and each frame starts straight from idle. The control word carried in that frame is expected to start the conversion. All analogue minimum times are parameters in nanoseconds. They are turned into clock counts, rounded up, from the clock period parameter.

Top module: `adc_xfer_ctrl`

## Requirements
- R1: While reset is held, `conv_start` is 0, `frame_n` is 1, `ser_clk` is 1, `ser_out` is 0 and `res_valid` is 0.
- R2: Each `conv_start` pulse lasts exactly ceil(PULSE_NS/CLK_NS) cycles (10 at the defaults).
- R3: A rising edge of `conv_start`, or a falling edge of `frame_n` in software mode, comes at least ACQ_CYC = ceil(ACQ_NS/CLK_NS) cycles (40 at the defaults) after the cycle in which `busy` is first seen low. When `sample_en` stays high and the conversion outlasts the frame, the gap is exactly ACQ_CYC.
- R4: In hardware mode the frame begins in the cycle right after the last `conv_start` cycle. It does not wait for `busy`, so it overlaps the conversion. `conv_start` is never high while `frame_n` is low.
- R5: A frame holds `frame_n` low for 32*SCLK_HALF cycles. Within each bit, `ser_clk` is low for the first SCLK_HALF cycles and high for the next SCLK_HALF. Outside a frame `ser_clk` idles high.
- R6: `ctrl_word` is captured in the cycle before the frame starts. It is sent on `ser_out` from bit 15 down to bit 0, and each bit changes only when `ser_clk` falls.
- R7: `ser_in` is sampled on each rising `ser_clk`, most significant bit first. `result` holds the low 12 bits of the received word, with `res_valid` high for the one cycle in which `frame_n` returns high.
- R8: A new cycle starts only after a falling edge of `busy` has been seen since the previous start. It never starts while `busy` is high, however long the conversion takes.
- R9: With `sw_start_mode` high, `conv_start` stays 0 and frames start directly from idle.
- R10: `sample_en` is looked at only in idle. While it is low in idle, neither `conv_start` nor `frame_n` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Allow new sampling cycles |
| sw_start_mode | input | 1 | Start conversions through the control word; strobe unused |
| ctrl_word | input | 16 | Control word sent in the next frame |
| busy | input | 1 | Converter busy flag, synchronous to `clk` |
| ser_in | input | 1 | Serial data from the converter |
| conv_start | output | 1 | Convert-start strobe, active high |
| frame_n | output | 1 | Frame sync, active low |
| ser_clk | output | 1 | Serial clock |
| ser_out | output | 1 | Serial data to the converter |
| result | output | 12 | Last received conversion result |
| res_valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
Every timing relation is fixed in clock cycles. A busy fall seen in cycle f allows the next strobe in cycle f+40 at the earliest. The frame starts in the cycle after the 10th strobe cycle and lasts 64 cycles. The result is flagged in the 65th cycle counted from the frame start. The bench holds a behavioural model that advances on each rising edge from the same inputs. It compares every output at the following falling edge, so each check lands in the cycle where the value is due and not one edge early or late. Separate counters measure the busy-to-strobe distance and the strobe width at the ports.

// File: rtl/adc_xfer_pkg.sv
package adc_xfer_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PULSE = 2'd1,
    SQ_XFER  = 2'd2,
    SQ_WAIT  = 2'd3
  } seq_state_t;

  function automatic int ns_to_cyc(input int ns, input int clk_ns, input int floor_cyc);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < floor_cyc) ? floor_cyc : c;
  endfunction

endpackage

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
  parameter int ACQ_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic busy_fell,
  output logic gap_ok
);
  localparam int GW = $clog2(ACQ_CYC + 1);

  logic          busy_q;
  logic [GW-1:0] gap_q, gap_n;

  assign busy_fell = busy_q & ~busy;
  assign gap_ok    = (gap_q >= GW'(ACQ_CYC - 1));

  always_comb begin
    gap_n = gap_q;
    if (busy_fell)                gap_n = GW'(1);
    else if (gap_q != GW'(ACQ_CYC)) gap_n = gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gap_q  <= GW'(ACQ_CYC);
    end else begin
      busy_q <= busy;
      gap_q  <= gap_n;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_xfer_pkg::*;
#(
  parameter int PULSE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic sw_start_mode,
  input  logic gap_ok,
  input  logic busy_fell,
  input  logic frame_done,
  output logic conv_start,
  output logic frame_start
);
  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  seq_state_t    st_q, st_n;
  logic [PW-1:0] pcnt_q, pcnt_n;
  logic          fell_q, fell_n;
  logic          leave_idle, pulse_last;

  assign leave_idle = (st_q == SQ_IDLE) && sample_en && gap_ok;
  assign pulse_last = (st_q == SQ_PULSE) && (pcnt_q == PW'(PULSE_CYC - 1));
  assign frame_start = (leave_idle && sw_start_mode) || pulse_last;
  assign conv_start  = (st_q == SQ_PULSE);

  always_comb begin
    st_n   = st_q;
    pcnt_n = pcnt_q;
    case (st_q)
      SQ_IDLE: if (leave_idle) begin
        st_n   = sw_start_mode ? SQ_XFER : SQ_PULSE;
        pcnt_n = '0;
      end
      SQ_PULSE: begin
        if (pulse_last) st_n = SQ_XFER;
        else            pcnt_n = pcnt_q + 1'b1;
      end
      SQ_XFER: if (frame_done) st_n = SQ_WAIT;
      SQ_WAIT: if (fell_q) st_n = SQ_IDLE;
      default: st_n = SQ_IDLE;
    endcase
    fell_n = fell_q;
    if (leave_idle) fell_n = 1'b0;
    if (busy_fell)  fell_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      pcnt_q <= '0;
      fell_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      pcnt_q <= pcnt_n;
      fell_q <= fell_n;
    end
  end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int WORD_W = 16,
  parameter int RES_W  = 12,
  parameter int HALF   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic             sdi,
  output logic             done,
  output logic             sclk,
  output logic             sync_n,
  output logic             sdo,
  output logic [RES_W-1:0] rx_bits
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = $clog2(WORD_W);

  logic              act_q, act_n;
  logic              lvl_q, lvl_n;
  logic              done_q, done_n;
  logic [HW-1:0]     hcnt_q, hcnt_n;
  logic [BW-1:0]     bcnt_q, bcnt_n;
  logic [WORD_W-1:0] tx_q, tx_n;
  logic [RES_W-1:0]  rx_q, rx_n;

  always_comb begin
    act_n  = act_q;
    lvl_n  = lvl_q;
    hcnt_n = hcnt_q;
    bcnt_n = bcnt_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    done_n = 1'b0;
    if (start) begin
      act_n  = 1'b1;
      lvl_n  = 1'b0;
      hcnt_n = '0;
      bcnt_n = '0;
      tx_n   = tx_word;
    end else if (act_q) begin
      if (hcnt_q == HW'(HALF - 1)) begin
        hcnt_n = '0;
        if (!lvl_q) begin
          lvl_n = 1'b1;
          rx_n  = {rx_q[RES_W-2:0], sdi};
        end else begin
          lvl_n = 1'b0;
          tx_n  = {tx_q[WORD_W-2:0], 1'b0};
          if (bcnt_q == BW'(WORD_W - 1)) begin
            act_n  = 1'b0;
            done_n = 1'b1;
          end else begin
            bcnt_n = bcnt_q + 1'b1;
          end
        end
      end else begin
        hcnt_n = hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      lvl_q  <= 1'b0;
      done_q <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      act_q  <= act_n;
      lvl_q  <= lvl_n;
      done_q <= done_n;
      hcnt_q <= hcnt_n;
      bcnt_q <= bcnt_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
    end
  end

  assign done    = done_q;
  assign sclk    = ~act_q | lvl_q;
  assign sync_n  = ~act_q;
  assign sdo     = act_q & tx_q[WORD_W-1];
  assign rx_bits = rx_q;
endmodule

// File: rtl/adc_xfer_ctrl.sv
module adc_xfer_ctrl
  import adc_xfer_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter int PULSE_NS   = 100,
  parameter int ACQ_NS     = 400,
  parameter int SCLK_HALF  = 2,
  parameter int FRAME_BITS = 16,
  parameter int RES_BITS   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_en,
  input  logic                  sw_start_mode,
  input  logic [FRAME_BITS-1:0] ctrl_word,
  input  logic                  busy,
  input  logic                  ser_in,
  output logic                  conv_start,
  output logic                  frame_n,
  output logic                  ser_clk,
  output logic                  ser_out,
  output logic [RES_BITS-1:0]   result,
  output logic                  res_valid
);
  localparam int PULSE_CYC = ns_to_cyc(PULSE_NS, CLK_NS, 1);
  localparam int ACQ_CYC   = ns_to_cyc(ACQ_NS, CLK_NS, 3);

  logic busy_fell, gap_ok, frame_start, frame_done;

  adc_gap_timer #(.ACQ_CYC(ACQ_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .busy_fell(busy_fell), .gap_ok(gap_ok)
  );

  adc_conv_seq #(.PULSE_CYC(PULSE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .sw_start_mode(sw_start_mode), .gap_ok(gap_ok), .busy_fell(busy_fell),
    .frame_done(frame_done), .conv_start(conv_start), .frame_start(frame_start)
  );

  adc_frame_shift #(.WORD_W(FRAME_BITS), .RES_W(RES_BITS), .HALF(SCLK_HALF)) u_frm (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .tx_word(ctrl_word),
    .sdi(ser_in), .done(frame_done), .sclk(ser_clk), .sync_n(frame_n),
    .sdo(ser_out), .rx_bits(result)
  );

  assign res_valid = frame_done;
endmodule

// File: rtl/adc_xfer_ctrl_chk.sv
module adc_xfer_ctrl_chk #(
  parameter int PULSE_CYC = 10,
  parameter int ACQ_CYC   = 40
) (
  input logic clk,
  input logic rst_n,
  input logic sw_start_mode,
  input logic busy,
  input logic conv_start,
  input logic frame_n,
  input logic ser_clk,
  input logic ser_out,
  input logic res_valid
);
  logic [15:0] hi_len_q;
  logic [15:0] since_fall_q;
  logic        busy_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len_q     <= '0;
      since_fall_q <= 16'(ACQ_CYC);
      busy_d_q     <= 1'b0;
    end else begin
      busy_d_q <= busy;
      hi_len_q <= conv_start ? hi_len_q + 16'd1 : 16'd0;
      if (busy_d_q && !busy)                 since_fall_q <= 16'd1;
      else if (since_fall_q < 16'(ACQ_CYC))  since_fall_q <= since_fall_q + 16'd1;
    end
  end

  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_start) |-> (hi_len_q == 16'(PULSE_CYC)));

  p_acq_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(conv_start) || (sw_start_mode && $fell(frame_n))) |-> (since_fall_q >= 16'(ACQ_CYC)));

  p_no_strobe_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> !conv_start);

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |-> ser_clk);

  p_sdo_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && !$fell(frame_n) && !$fell(ser_clk)) |-> $stable(ser_out));

  p_valid_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(frame_n));

  p_sw_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start_mode |-> !conv_start);
endmodule

bind adc_xfer_ctrl adc_xfer_ctrl_chk #(.PULSE_CYC(PULSE_CYC), .ACQ_CYC(ACQ_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_start_mode(sw_start_mode), .busy(busy),
  .conv_start(conv_start), .frame_n(frame_n), .ser_clk(ser_clk),
  .ser_out(ser_out), .res_valid(res_valid)
);

// File: tb/adc_xfer_ctrl_bench.sv
module adc_xfer_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H     = 2;
  localparam int PC    = 10;
  localparam int ACQ   = 40;
  localparam int FCYC  = 32 * H;
  localparam int WDOG  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0;
  logic        sw_mode = 1'b0;
  logic [15:0] ctrl = 16'hA5C3;
  logic        busy_drv = 1'b0;
  logic        sdi = 1'b0;
  logic        conv_start, frame_n, ser_clk, ser_out, res_valid;
  logic [11:0] result;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_xfer_ctrl u_adc_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sw_start_mode(sw_mode),
    .ctrl_word(ctrl), .busy(busy_drv), .ser_in(sdi), .conv_start(conv_start),
    .frame_n(frame_n), .ser_clk(ser_clk), .ser_out(ser_out),
    .result(result), .res_valid(res_valid)
  );

  int nvec = 0, nerr = 0;
  bit finished = 0, run_chk = 0, exact = 0, idle_watch = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mst, pc, t, gap;
  bit fell, bprev;
  logic [15:0] ctrl_lat, rxw, adc_word;
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; pc = 0; t = 0; gap = ACQ; fell = 0; bprev = 0;
      ctrl_lat = '0; rxw = '0; adc_word = '0;
    end else begin
      bit fall_now;
      fall_now = bprev && !busy_drv;
      case (mst)
        0: if (sample_en && gap >= ACQ - 1) begin
             fell = 0;
             if (sw_mode) begin
               mst = 2; t = 0; ctrl_lat = ctrl;
               seed = seed * 32'd1103515245 + 32'd12345; adc_word = seed[23:8];
             end else begin
               mst = 1; pc = 0;
             end
           end
        1: if (pc == PC - 1) begin
             mst = 2; t = 0; ctrl_lat = ctrl;
             seed = seed * 32'd1103515245 + 32'd12345; adc_word = seed[23:8];
           end else pc++;
        2: begin
             if (t < FCYC && (t % (2*H)) == H - 1) rxw = {rxw[14:0], sdi};
             if (t == FCYC) mst = 3; else t++;
           end
        default: if (fell) mst = 0;
      endcase
      if (fall_now) fell = 1;
      if (fall_now) gap = 1; else if (gap < ACQ) gap++;
      bprev = busy_drv;
    end
  end

  // compare, measure, and converter model at the falling edge
  int cyc = 0, conv_len = 200, conv_left = 0, fall_cyc = -1, hi_len = 0;
  int overlap = 0, sw_strobes = 0, sw_frames = 0, idle_viol = 0;
  bit pconv = 0, psync = 1;

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      bit act;
      int bi;
      cyc++;
      act = (mst == 2) && (t < FCYC);
      bi  = act ? (15 - t / (2*H)) : 0;
      chk(conv_start == (mst == 1), "R2 conv_start", conv_start, mst == 1);
      chk(frame_n == !act, "R5 frame_n", frame_n, !act);
      chk(ser_clk == (act ? ((t % (2*H)) >= H) : 1'b1), "R5 ser_clk", ser_clk,
          act ? ((t % (2*H)) >= H) : 1);
      chk(ser_out == (act ? ctrl_lat[bi] : 1'b0), "R6 ser_out", ser_out,
          act ? ctrl_lat[bi] : 0);
      chk(res_valid == ((mst == 2) && (t == FCYC)), "R7 res_valid", res_valid,
          (mst == 2) && (t == FCYC));
      if ((mst == 2) && (t == FCYC)) begin
        chk(result == adc_word[11:0], "R7 result", result, adc_word[11:0]);
        chk(result == rxw[11:0], "R7 result vs sampled", result, rxw[11:0]);
      end
      // R3 / R8: strobe timing relative to busy
      if (conv_start && !pconv) begin
        chk(!busy_drv, "R8 strobe while busy", busy_drv, 0);
        if (fall_cyc >= 0) begin
          if (exact) chk(cyc - fall_cyc == ACQ, "R3 gap exact", cyc - fall_cyc, ACQ);
          else       chk(cyc - fall_cyc >= ACQ, "R3 gap min", cyc - fall_cyc, ACQ);
          fall_cyc = -1;
        end
      end
      if (!conv_start && pconv) chk(hi_len == PC, "R2 pulse width", hi_len, PC);
      hi_len = conv_start ? (pconv ? hi_len + 1 : 1) : 0;
      if (!frame_n && psync) begin
        if (busy_drv) overlap++;
        if (sw_mode) begin
          sw_frames++;
          if (fall_cyc >= 0) begin
            if (exact) chk(cyc - fall_cyc == ACQ, "R3 sw gap exact", cyc - fall_cyc, ACQ);
            else       chk(cyc - fall_cyc >= ACQ, "R3 sw gap min", cyc - fall_cyc, ACQ);
            fall_cyc = -1;
          end
        end
      end
      if (sw_mode && conv_start) sw_strobes++;
      if (idle_watch && (conv_start || !frame_n)) idle_viol++;
      // converter model
      if (conv_left > 0) conv_left--;
      if (!sw_mode && conv_start && !pconv) conv_left = conv_len;
      if (sw_mode && frame_n && !psync) conv_left = conv_len;
      if (busy_drv && conv_left == 0) fall_cyc = cyc;
      busy_drv = (conv_left > 0);
      sdi = act ? adc_word[bi] : 1'b0;
      pconv = conv_start;
      psync = frame_n;
      ctrl = {ctrl[14:0], ctrl[15] ^ ctrl[13] ^ ctrl[12] ^ ctrl[10]};
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog R1-R10 run actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(conv_start == 0, "R1 conv_start", conv_start, 0);
    chk(frame_n == 1, "R1 frame_n", frame_n, 1);
    chk(ser_clk == 1, "R1 ser_clk", ser_clk, 1);
    chk(ser_out == 0, "R1 ser_out", ser_out, 0);
    chk(res_valid == 0, "R1 res_valid", res_valid, 0);
    rst_n = 1'b1;
    run_chk = 1;
    // hardware start, conversion longer than the frame
    sample_en = 1'b1; exact = 1;
    repeat (900) @(negedge clk);
    chk(overlap > 0, "R4 frame during busy", overlap, 1);
    // short conversion ending inside the frame
    exact = 0; conv_len = 30;
    repeat (600) @(negedge clk);
    // R10: idle with sample_en low
    sample_en = 1'b0;
    repeat (300) @(negedge clk);
    idle_watch = 1;
    repeat (200) @(negedge clk);
    idle_watch = 0;
    chk(idle_viol == 0, "R10 idle activity", idle_viol, 0);
    // R9: software start mode
    sw_mode = 1'b1; conv_len = 150; sample_en = 1'b1;
    repeat (300) @(negedge clk);
    exact = 1;
    repeat (700) @(negedge clk);
    chk(sw_strobes == 0, "R9 strobe in sw mode", sw_strobes, 0);
    chk(sw_frames > 0, "R9 sw frames run", sw_frames, 1);
    finished = 1;
    summary();
    $finish;
  end
endmodule